// File: doc/BRIEF.md
# Self-Test Pattern Checker with Comma Alignment

This block checks the receive side of a serial link's built-in self-test. Its input is the byte stream from an 8b/10b decoder that has already aligned bytes: one data byte, a control-character flag and a decode-error flag on each valid cycle. The checker waits in a hunting state until it sees a run of consecutive comma characters. After that run it runs a local pseudo-random byte generator in step with the incoming data and compares every data byte with the byte it expects.

A frame of checked data is either long or short, selected by an input. At the end of a frame the checker goes back to hunting until the next comma run. A single comma inside a frame re-arms the checker, and the reference restarts at the following data byte. Any wrong byte, unexpected control character or decode error that arrives while the checker is armed sets a sticky error flag and bumps a saturating error-byte counter. Only a one-cycle soft reset command, or the hardware reset, clears the flag and the counter. Unencoded raw data contains false commas, so it keeps re-arming the checker and never gives a clean run.

Top module: `bist_rx_checker`

## Requirements
- R1: After hardware reset, `err_flag` is 0, `checking` is 0 and `err_count` is 0.
- R2: `checking` rises at the clock edge that takes in the MIN_COMMAS-th consecutive valid comma. A comma is a valid byte with `rx_k`=1, `rx_data`=8'hBC and `rx_code_err`=0. A valid non-comma byte in between restarts the count. Cycles with `rx_valid`=0 do not break the run.
- R3: While `checking` is 0, no data byte, control character or decode error changes `err_flag` or `err_count`.
- R4: The reference is a 23-bit Fibonacci LFSR with polynomial x^23+x^18+1 (new bit = s[22]^s[17], shifted into bit 0) and seed 23'h7FFFFF. Each byte is made of 8 new bits, the first in bit 0. The first data byte after a comma is compared with the first byte from the seed.
- R5: While the checker is armed, a data byte that differs from the expected byte in any bit sets `err_flag` and adds 1 to `err_count`. A correct byte changes neither.
- R6: `long_sel`=1 selects a frame of LONG_LEN data bytes and 0 selects SHORT_LEN. `checking` falls at the edge that takes in the last byte of the frame, and data after that point is ignored until a new comma run.
- R7: A single valid comma while checking a frame keeps `checking` at 1 and restarts the reference from the seed at the next data byte.
- R8: `err_count` is ERR_W bits wide and stays at 2^ERR_W-1 once it gets there.
- R9: `soft_rst`=1 at a clock edge clears `err_flag` and `err_count` and returns to hunting. This takes priority over an error byte in the same cycle.
- R10: While armed, a byte with `rx_code_err`=1, or a control character other than a comma, counts as an error byte. A comma that carries `rx_code_err`=1 is not counted toward the arming run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | One-cycle self-clearing soft reset command |
| long_sel | input | 1 | Frame length select: 1 long, 0 short |
| rx_valid | input | 1 | Decoded byte valid this cycle |
| rx_k | input | 1 | Byte is a control character |
| rx_data | input | 8 | Decoded byte |
| rx_code_err | input | 1 | Decoder reported a code or disparity error |
| err_flag | output | 1 | Sticky error flag |
| checking | output | 1 | Checker armed and comparing |
| err_count | output | ERR_W | Saturating count of error bytes |

## Verification
Two things can happen on the same edge: a soft reset and the arrival of an error byte. The bench drives `soft_rst` together with a corrupted byte while a frame is being checked, and then expects the flag and the counter to read zero and `checking` to be low. A second clash occurs when a comma lands on the last byte slot of a frame. The bench judges it by whether the data that follows is compared against the bytes from the seed.

// File: rtl/bist_chk_pkg.sv
package bist_chk_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CHECK = 2'd2
  } sync_st_e;

  localparam logic [7:0] COMMA_CHAR = 8'hBC;
  localparam int         REF_W      = 23;

  // Advance the reference by one byte: returns {next_state, byte}
  function automatic logic [REF_W+7:0] prbs_byte_step(input logic [REF_W-1:0] s);
    logic [REF_W-1:0] t;
    logic [7:0]       b;
    logic             nb;
    t = s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      nb   = t[22] ^ t[17];
      b[i] = nb;
      t    = {t[REF_W-2:0], nb};
    end
    return {t, b};
  endfunction

endpackage

// File: rtl/bist_prbs_ref.sv
module bist_prbs_ref
  import bist_chk_pkg::*;
#(
  parameter logic [REF_W-1:0] SEED = 23'h7FFFFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       adv,
  output logic [7:0] exp_byte
);

  logic [REF_W-1:0] ref_q, ref_d;
  logic [REF_W+7:0] step;

  always_comb begin
    step     = prbs_byte_step(ref_q);
    exp_byte = step[7:0];
    ref_d    = ref_q;
    if (load)     ref_d = SEED;
    else if (adv) ref_d = step[REF_W+7:8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ref_q <= SEED;
    else if (load | adv) ref_q <= ref_d;
  end

  // R4: the reference never falls into the all-zero lock-up state
  a_r4_ref_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    ref_q != '0);

endmodule

// File: rtl/bist_sync_fsm.sv
module bist_sync_fsm
  import bist_chk_pkg::*;
#(
  parameter int MIN_COMMAS = 3,
  parameter int LONG_LEN   = 8388607,
  parameter int SHORT_LEN  = 13458
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic long_sel,
  input  logic rx_valid,
  input  logic is_comma,
  output logic checking,
  output logic cmp_en,
  output logic load_ref
);

  localparam int MAX_LEN = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
  localparam int FC_W    = $clog2(MAX_LEN + 1);
  localparam int CC_W    = $clog2(MIN_COMMAS + 1);

  sync_st_e         st_q, st_d;
  logic [CC_W-1:0]  cc_q, cc_d;
  logic [FC_W-1:0]  fc_q, fc_d;
  logic [FC_W-1:0]  frame_len;
  logic             upd;

  assign frame_len = long_sel ? FC_W'(LONG_LEN) : FC_W'(SHORT_LEN);
  assign cmp_en    = rx_valid & ~is_comma & (st_q != ST_HUNT) & ~soft_rst;
  assign load_ref  = (st_d == ST_ARMED);
  assign checking  = (st_q != ST_HUNT);
  assign upd       = soft_rst | rx_valid;

  always_comb begin
    st_d = st_q;
    cc_d = cc_q;
    fc_d = fc_q;
    if (soft_rst) begin
      st_d = ST_HUNT;
      cc_d = '0;
      fc_d = '0;
    end else if (rx_valid) begin
      unique case (st_q)
        ST_HUNT: begin
          if (!is_comma) begin
            cc_d = '0;
          end else if (32'(cc_q) + 1 >= MIN_COMMAS) begin
            st_d = ST_ARMED;
            cc_d = '0;
          end else begin
            cc_d = cc_q + 1'b1;
          end
        end
        ST_ARMED: begin
          if (!is_comma) begin
            if (32'(frame_len) == 1) begin
              st_d = ST_HUNT;
              fc_d = '0;
            end else begin
              st_d = ST_CHECK;
              fc_d = FC_W'(1);
            end
          end
        end
        ST_CHECK: begin
          if (is_comma) begin
            st_d = ST_ARMED;
            fc_d = '0;
          end else if (32'(fc_q) + 1 >= 32'(frame_len)) begin
            st_d = ST_HUNT;
            fc_d = '0;
          end else begin
            fc_d = fc_q + 1'b1;
          end
        end
        default: begin
          st_d = ST_HUNT;
          cc_d = '0;
          fc_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_HUNT;
      cc_q <= '0;
      fc_q <= '0;
    end else if (upd) begin
      st_q <= st_d;
      cc_q <= cc_d;
      fc_q <= fc_d;
    end
  end

  // R2: arming only follows a valid comma
  a_r2_arm_on_comma: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(checking) |-> $past(rx_valid && is_comma));

  // R9: soft reset always returns to hunting
  a_r9_soft_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !checking);

  // R7: a comma seen while armed never drops the checker
  a_r7_comma_keeps_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (checking && rx_valid && is_comma && !soft_rst) |=> checking);

endmodule

// File: rtl/bist_err_accum.sv
module bist_err_accum #(
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cmp_en,
  input  logic             mismatch,
  output logic             err_flag,
  output logic [ERR_W-1:0] err_count
);

  localparam logic [ERR_W-1:0] CNT_MAX = '1;

  logic             bad;
  logic             flag_d;
  logic [ERR_W-1:0] cnt_d;
  logic             upd;

  assign bad = cmp_en & mismatch;
  assign upd = soft_rst | bad;

  always_comb begin
    flag_d = err_flag;
    cnt_d  = err_count;
    if (soft_rst) begin
      flag_d = 1'b0;
      cnt_d  = '0;
    end else if (bad) begin
      flag_d = 1'b1;
      if (err_count != CNT_MAX) cnt_d = err_count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag  <= 1'b0;
      err_count <= '0;
    end else if (upd) begin
      err_flag  <= flag_d;
      err_count <= cnt_d;
    end
  end

  // R5: the flag is sticky until a soft reset
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !soft_rst) |=> err_flag);

  // R8: the counter holds at its maximum
  a_r8_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CNT_MAX && !soft_rst) |=> err_count == CNT_MAX);

  // R5: the counter moves by at most one per cycle unless cleared
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> (err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1));

  // R9: soft reset clears both flag and counter
  a_r9_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!err_flag && err_count == '0));

endmodule

// File: rtl/bist_rx_checker.sv
module bist_rx_checker
  import bist_chk_pkg::*;
#(
  parameter int                 MIN_COMMAS = 3,
  parameter int                 LONG_LEN   = 8388607,
  parameter int                 SHORT_LEN  = 13458,
  parameter int                 ERR_W      = 16,
  parameter logic [REF_W-1:0]   SEED       = 23'h7FFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             long_sel,
  input  logic             rx_valid,
  input  logic             rx_k,
  input  logic [7:0]       rx_data,
  input  logic             rx_code_err,
  output logic             err_flag,
  output logic             checking,
  output logic [ERR_W-1:0] err_count
);

  logic       is_comma;
  logic       cmp_en;
  logic       load_ref;
  logic [7:0] exp_byte;
  logic       mismatch;

  // R10: a comma with a decode error does not count as a comma
  assign is_comma = rx_k & (rx_data == COMMA_CHAR) & ~rx_code_err;
  assign mismatch = rx_code_err | rx_k | (rx_data != exp_byte);

  bist_sync_fsm #(
    .MIN_COMMAS (MIN_COMMAS),
    .LONG_LEN   (LONG_LEN),
    .SHORT_LEN  (SHORT_LEN)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .long_sel (long_sel),
    .rx_valid (rx_valid),
    .is_comma (is_comma),
    .checking (checking),
    .cmp_en   (cmp_en),
    .load_ref (load_ref)
  );

  bist_prbs_ref #(
    .SEED (SEED)
  ) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_ref),
    .adv      (cmp_en),
    .exp_byte (exp_byte)
  );

  bist_err_accum #(
    .ERR_W (ERR_W)
  ) u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .cmp_en    (cmp_en),
    .mismatch  (mismatch),
    .err_flag  (err_flag),
    .err_count (err_count)
  );

  // R3: nothing is counted while hunting
  a_r3_quiet_when_hunting: assert property (@(posedge clk) disable iff (!rst_n)
    (!checking && !soft_rst) |=> $stable(err_count) && $stable(err_flag));

endmodule

// File: tb/bist_rx_checker_tb.sv
module bist_rx_checker_tb;

  localparam int MINC  = 3;
  localparam int LLEN  = 20;
  localparam int SLEN  = 7;
  localparam int EW    = 4;
  localparam int CMAX  = 15;
  localparam logic [22:0] SEED = 23'h7FFFFF;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          soft_rst;
  logic          long_sel;
  logic          rx_valid;
  logic          rx_k;
  logic [7:0]    rx_data;
  logic          rx_code_err;
  logic          err_flag;
  logic          checking;
  logic [EW-1:0] err_count;

  int total = 0;
  int bad   = 0;

  // bench model
  int          ms;
  int          mcc;
  int          mfc;
  logic [22:0] mref;
  bit          mflag;
  int          mcnt;

  always #5 clk = ~clk;

  bist_rx_checker #(
    .MIN_COMMAS (MINC),
    .LONG_LEN   (LLEN),
    .SHORT_LEN  (SLEN),
    .ERR_W      (EW),
    .SEED       (SEED)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .long_sel    (long_sel),
    .rx_valid    (rx_valid),
    .rx_k        (rx_k),
    .rx_data     (rx_data),
    .rx_code_err (rx_code_err),
    .err_flag    (err_flag),
    .checking    (checking),
    .err_count   (err_count)
  );

  function automatic logic [7:0] tb_next(inout logic [22:0] r);
    logic [7:0] v;
    logic fb;
    for (int k = 0; k < 8; k++) begin
      fb   = r[22] ^ r[17];
      v[k] = fb;
      r    = {r[21:0], fb};
    end
    return v;
  endfunction

  function automatic logic [7:0] peek();
    logic [22:0] t;
    t = mref;
    return tb_next(t);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(err_flag == mflag, {tag, " flag"}, int'(err_flag), int'(mflag));
    check(checking == (ms != 0), {tag, " checking"}, int'(checking), int'(ms != 0));
    check(int'(err_count) == mcnt, {tag, " count"}, int'(err_count), mcnt);
  endtask

  task automatic model(input bit sr, input bit v, input bit k, input logic [7:0] d,
                       input bit ce, input bit ls);
    bit comma;
    bit e;
    logic [7:0] x;
    comma = v && k && d == 8'hBC && !ce;
    if (sr) begin
      ms = 0; mcc = 0; mfc = 0; mflag = 0; mcnt = 0;
    end else if (v) begin
      if (ms == 0) begin
        if (comma) begin
          mcc++;
          if (mcc >= MINC) begin ms = 1; mcc = 0; mref = SEED; end
        end else mcc = 0;
      end else if (comma) begin
        ms = 1; mfc = 0; mref = SEED;
      end else begin
        x = tb_next(mref);
        e = ce || k || (d != x);
        if (e) begin mflag = 1; if (mcnt < CMAX) mcnt++; end
        mfc++;
        if (mfc == (ls ? LLEN : SLEN)) begin ms = 0; mfc = 0; end
        else ms = 2;
      end
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input string tag, input bit sr, input bit v, input bit k,
                      input logic [7:0] d, input bit ce);
    soft_rst = sr; rx_valid = v; rx_k = k; rx_data = d; rx_code_err = ce;
    @(posedge clk);
    model(sr, v, k, d, ce, long_sel);
    @(negedge clk);
    soft_rst = 1'b0; rx_valid = 1'b0;
    compare(tag);
  endtask

  task automatic commas(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 1, 1, 8'hBC, 0);
  endtask

  task automatic good(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 1, 0, peek(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; soft_rst = 0; long_sel = 0; rx_valid = 0; rx_k = 0;
    rx_data = 0; rx_code_err = 0;
    ms = 0; mcc = 0; mfc = 0; mref = SEED; mflag = 0; mcnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare("R1 reset");

    // R2: broken runs, idle gaps, then a full run
    commas("R2 partial", 2);
    step("R2 break", 0, 1, 0, 8'h12, 0);
    commas("R2 partial2", 2);
    step("R2 gap", 0, 0, 1, 8'hBC, 0);
    commas("R2 arm", 1);
    check(checking == 1'b1, "R2 armed after run", int'(checking), 1);

    // R4/R6: clean short frame, then checking falls
    good("R4 short frame", SLEN);
    check(checking == 1'b0, "R6 short end", int'(checking), 0);
    check(err_flag == 1'b0, "R4 clean frame", int'(err_flag), 0);

    // R3/R10: junk while hunting is ignored; code-error comma breaks the run
    step("R3 junk", 0, 1, 0, 8'h00, 0);
    step("R3 kchar", 0, 1, 1, 8'h7C, 0);
    step("R10 cerr hunt", 0, 1, 0, 8'h55, 1);
    commas("R10 run", 2);
    step("R10 bad comma", 0, 1, 1, 8'hBC, 1);
    commas("R10 run2", 2);
    check(checking == 1'b0, "R10 errored comma not counted", int'(checking), 0);
    check(err_count == 0, "R3 count untouched", int'(err_count), 0);
    commas("R10 run3", 1);

    // R6: long frame
    long_sel = 1'b1;
    good("R6 long frame", LLEN - 1);
    check(checking == 1'b1, "R6 long still on", int'(checking), 1);
    good("R6 long last", 1);
    check(checking == 1'b0, "R6 long end", int'(checking), 0);
    long_sel = 1'b0;

    // R5 sweep: one corrupted bit at each position of a short frame
    for (int p = 0; p < SLEN; p++) begin
      step("R9 clear", 1, 0, 0, 8'h00, 0);
      commas("R5 sweep arm", MINC);
      for (int i = 0; i < SLEN; i++) begin
        if (i == p) step("R5 sweep err", 0, 1, 0, peek() ^ 8'(1 << (p % 8)), 0);
        else good("R5 sweep ok", 1);
      end
      check(err_count == 1, "R5 one error per frame", int'(err_count), 1);
    end

    // R10: control char and code error while armed count
    step("R9 clear2", 1, 0, 0, 8'h00, 0);
    commas("R10 arm", MINC);
    step("R10 kchar armed", 0, 1, 1, 8'h3C, 0);
    step("R10 cerr armed", 0, 1, 0, 8'h00, 1);
    check(err_count == 2, "R10 both counted", int'(err_count), 2);

    // R7: mid-frame comma restarts the reference from the seed
    step("R9 clear3", 1, 0, 0, 8'h00, 0);
    commas("R7 arm", MINC);
    good("R7 part", 3);
    commas("R7 mid comma", 1);
    check(checking == 1'b1, "R7 stays armed", int'(checking), 1);
    good("R7 restart", SLEN);
    check(err_flag == 1'b0, "R7 seed restart clean", int'(err_flag), 0);
    // comma on the last slot of a frame
    commas("R7 arm2", MINC);
    good("R7 near end", SLEN - 1);
    commas("R7 last slot comma", 1);
    good("R7 after", 2);
    check(err_flag == 1'b0, "R7 last slot restart", int'(err_flag), 0);

    // R9: soft reset together with an error byte
    commas("R9 arm", 1);
    good("R9 some", 2);
    step("R9 collide", 1, 1, 0, peek() ^ 8'hFF, 0);
    check(err_flag == 0 && err_count == 0 && checking == 0, "R9 soft wins",
          int'(err_count), 0);

    // R8: saturation
    for (int f = 0; f < 3; f++) begin
      commas("R8 arm", MINC);
      for (int i = 0; i < SLEN; i++) step("R8 err", 0, 1, 0, peek() ^ 8'h80, 0);
    end
    check(err_count == CMAX, "R8 saturated", int'(err_count), CMAX);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule